// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches page-to-frame mappings for a memory management unit. Each entry holds a virtual page number, an address-space tag, a frame number, permission bits and a page-valid bit. A lookup compares the presented page number and address-space tag against every occupied entry at once. In the same cycle it reports one of three results: a hit with frame and permissions, a fault (the mapping is cached but the page is marked not present), or a miss.

On a miss, an external walker fetches the mapping and presents it on the refill port. The refill is written at the next clock edge. If the refill key is already cached, that entry is rewritten in place. Otherwise the lowest-numbered empty slot is used, and when no slot is empty a tree-based pseudo-LRU victim is replaced. Two flush inputs clear either the whole cache or only the entries of one address space, which lets mappings of many processes coexist between context switches.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss.
- R2: A lookup hits only when an occupied entry matches both the page number and the address-space tag and its page-valid bit is 1. The hit and that entry's frame and permission bits appear in the same cycle as the request.
- R3: With a request present, exactly one of hit, miss and fault is asserted. Frame and permission outputs are zero whenever hit is low.
- R4: An entry that matches but has page-valid 0 reports a fault and gives no translation: frame and permissions read zero.
- R5: A refill is visible from the clock edge that ends its cycle. A lookup of the same key in the refill's own cycle still sees the old contents.
- R6: A refill whose page number and tag already match an entry overwrites that entry. No duplicate is made and no other entry is displaced.
- R7: A refill of a new key goes to the lowest-numbered empty slot whenever one exists, so no occupied entry is evicted.
- R8: With all slots occupied, a new key replaces the slot named by a binary tree of N-1 bits. Node k has children 2k+1 (lower half) and 2k+2 (upper half), and a node bit of 1 selects the upper half. Every lookup that matches an entry and every accepted refill sets each node on that slot's path to point away from it, with the lookup applied before the refill in the same cycle. The tree is all zero after reset.
- R9: Asserting the flush-all input empties every entry from the next cycle on.
- R10: The per-tag flush empties exactly the entries whose tag equals the given tag and leaves the others usable.
- R11: A refill in the same cycle as either flush input is dropped. Flush-all takes precedence over the per-tag flush.
- R12: Without a request, hit, miss, fault, frame and permission outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry marked not present |
| lk_pfn | output | PFN_W | Frame number on hit, else zero |
| lk_perm | output | PERM_W | Permission bits on hit, else zero |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Refill page number |
| fill_asid | input | ASID_W | Refill address-space tag |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_perm | input | PERM_W | Refill permission bits |
| fill_pvalid | input | 1 | Refill page-valid bit |
| flush_all | input | 1 | Empty every entry |
| flush_asid_valid | input | 1 | Empty entries with a given tag |
| flush_asid | input | ASID_W | Tag for the selective flush |

## Verification
The hardest state to reach is a full cache whose replacement tree has been shaped by a long mix of matching lookups and refills, because only then does the victim choice differ between policies. The bench keeps its own model of slot contents and the tree. It drives many rounds of pseudo-random lookups to existing keys, each followed by a refill of a fresh key, and probes both the evicted key and the survivors. The model follows every matching probe too. Holes made by a per-tag flush are refilled to show that empty slots are taken before any eviction.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_HIT   = 2'd1,
      LK_MISS  = 2'd2,
      LK_FAULT = 2'd3
   } lk_state_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int N      = 16,
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic [N-1:0]             ent_valid,
   input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
   input  logic [N-1:0][ASID_W-1:0] ent_asid,
   input  logic [VPN_W-1:0]         key_vpn,
   input  logic [ASID_W-1:0]        key_asid,
   output logic [N-1:0]             match_vec
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match_vec[g] = ent_valid[g] && (ent_vpn[g] == key_vpn)
                            && (ent_asid[g] == key_asid);
   end
endmodule

// File: rtl/xlat_plru.sv
module xlat_plru #(
   parameter int N = 16,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_a_en,
   input  logic [IW-1:0] touch_a_idx,
   input  logic          touch_b_en,
   input  logic [IW-1:0] touch_b_idx,
   output logic [IW-1:0] victim
);
   logic [N-2:0] tree_q, tree_d;

   function automatic logic [N-2:0] walk_touch(input logic [N-2:0] t,
                                                input logic [IW-1:0] w);
      int node;
      node = 0;
      for (int l = 0; l < IW; l++) begin
         logic b;
         b       = w[IW-1-l];
         t[node] = ~b;
         node    = 2 * node + 1 + int'(b);
      end
      return t;
   endfunction

   always_comb begin
      tree_d = tree_q;
      if (touch_a_en) tree_d = walk_touch(tree_d, touch_a_idx);
      if (touch_b_en) tree_d = walk_touch(tree_d, touch_b_idx);
   end

   always_comb begin
      int node;
      node = 0;
      for (int l = 0; l < IW; l++) node = 2 * node + 1 + int'(tree_q[node]);
      victim = IW'(node - (N - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tree_q <= '0;
      else        tree_q <= tree_d;
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   parameter int PERM_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_fault,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              fill_pvalid,
   input  logic              flush_all,
   input  logic              flush_asid_valid,
   input  logic [ASID_W-1:0] flush_asid
);
   localparam int IW = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || ASID_W < 1 || PFN_W < 1 || PERM_W < 1) begin : g_bad_width
      $error("all field widths must be positive");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0]             ent_pv;
   logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
   logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
   logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
   logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;

   logic [ENTRIES-1:0] lk_vec, fill_vec;
   logic [IW-1:0]      lk_idx, fill_idx, free_idx, victim, fill_slot;
   logic               has_free, fill_take;
   lk_state_e          lk_state;

   xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) lk_match_i (
      .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .match_vec(lk_vec));

   xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) fill_match_i (
      .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
      .key_vpn(fill_vpn), .key_asid(fill_asid), .match_vec(fill_vec));

   always_comb begin
      lk_idx   = '0;
      fill_idx = '0;
      free_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_vec[i])   lk_idx   = IW'(i);
         if (fill_vec[i]) fill_idx = IW'(i);
      end
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (!ent_valid[i]) free_idx = IW'(i);
   end

   assign has_free  = ~&ent_valid;
   assign fill_take = fill_valid && !flush_all && !flush_asid_valid;
   assign fill_slot = (|fill_vec) ? fill_idx : (has_free ? free_idx : victim);

   xlat_plru #(.N(ENTRIES)) plru_i (
      .clk(clk), .rst_n(rst_n),
      .touch_a_en(lk_valid && (|lk_vec)), .touch_a_idx(lk_idx),
      .touch_b_en(fill_take), .touch_b_idx(fill_slot),
      .victim(victim));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid <= '0;
      end else if (flush_all) begin
         ent_valid <= '0;
      end else if (flush_asid_valid) begin
         for (int i = 0; i < ENTRIES; i++)
            if (ent_asid[i] == flush_asid) ent_valid[i] <= 1'b0;
      end else if (fill_valid) begin
         ent_valid[fill_slot] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_take) begin
         ent_vpn[fill_slot]  <= fill_vpn;
         ent_asid[fill_slot] <= fill_asid;
         ent_pfn[fill_slot]  <= fill_pfn;
         ent_perm[fill_slot] <= fill_perm;
         ent_pv[fill_slot]   <= fill_pvalid;
      end
   end

   always_comb begin
      if (!lk_valid)        lk_state = LK_IDLE;
      else if (!(|lk_vec))  lk_state = LK_MISS;
      else if (ent_pv[lk_idx]) lk_state = LK_HIT;
      else                  lk_state = LK_FAULT;
   end

   assign lk_hit   = (lk_state == LK_HIT);
   assign lk_miss  = (lk_state == LK_MISS);
   assign lk_fault = (lk_state == LK_FAULT);
   assign lk_pfn   = lk_hit ? ent_pfn[lk_idx]  : '0;
   assign lk_perm  = lk_hit ? ent_perm[lk_idx] : '0;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   parameter int PERM_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [VPN_W-1:0]   lk_vpn,
   input logic [ASID_W-1:0]  lk_asid,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               lk_fault,
   input logic [PFN_W-1:0]   lk_pfn,
   input logic [PERM_W-1:0]  lk_perm,
   input logic               fill_valid,
   input logic [VPN_W-1:0]   fill_vpn,
   input logic [ASID_W-1:0]  fill_asid,
   input logic               flush_all,
   input logic               flush_asid_valid,
   input logic [ASID_W-1:0]  flush_asid,
   input logic [ENTRIES-1:0] lk_vec
);
   assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

   assert_no_xlat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pfn == '0 && lk_perm == '0));

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

   assert_fill_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush_all && !flush_asid_valid) |=>
      (!lk_valid || lk_vpn != $past(fill_vpn) || lk_asid != $past(fill_asid)
       || lk_hit || lk_fault));

   assert_unique_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));

   assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !(lk_hit || lk_fault));

   assert_flush_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_asid_valid && !flush_all) |=>
      !(lk_valid && lk_asid == $past(flush_asid) && (lk_hit || lk_fault)));
endmodule

bind xlat_cache xlat_cache_chk #(
   .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
   .PFN_W(PFN_W), .PERM_W(PERM_W)
) chk_i (.*);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
   localparam int N = 16, VW = 20, AW = 8, FW = 20, RW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_valid = 0, fill_valid = 0, fill_pvalid = 0;
   logic flush_all = 0, flush_asid_valid = 0;
   logic [VW-1:0] lk_vpn = '0, fill_vpn = '0;
   logic [AW-1:0] lk_asid = '0, fill_asid = '0, flush_asid = '0;
   logic [FW-1:0] fill_pfn = '0;
   logic [RW-1:0] fill_perm = '0;
   logic lk_hit, lk_miss, lk_fault;
   logic [FW-1:0] lk_pfn;
   logic [RW-1:0] lk_perm;

   always #4 clk = ~clk;

   xlat_cache dut_i (.*);

   int checks = 0, errors = 0;
   bit done = 0;

   logic [VW-1:0] m_vpn  [N];
   logic [AW-1:0] m_asid [N];
   logic [FW-1:0] m_pfn  [N];
   logic [RW-1:0] m_perm [N];
   bit            m_ok   [N];
   bit            m_pv   [N];
   bit            m_tree [N-1];
   logic [VW-1:0] ev_vpn;
   logic [AW-1:0] ev_asid;
   bit            ev_any;
   logic [15:0]   lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int m_find(input logic [VW-1:0] v, input logic [AW-1:0] a);
      for (int i = 0; i < N; i++) if (m_ok[i] && m_vpn[i] == v && m_asid[i] == a) return i;
      return -1;
   endfunction

   function automatic void m_touch(input int w);
      int node = 0;
      for (int l = 0; l < 4; l++) begin
         int b = (w >> (3 - l)) & 1;
         m_tree[node] = (b == 0);
         node = 2 * node + 1 + b;
      end
   endfunction

   function automatic int m_victim();
      int node = 0;
      for (int l = 0; l < 4; l++) node = 2 * node + 1 + int'(m_tree[node]);
      return node - (N - 1);
   endfunction

   function automatic void m_fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                                  input logic [FW-1:0] p, input logic [RW-1:0] r, input bit pv);
      int s = m_find(v, a);
      ev_any = 0;
      if (s < 0) begin
         for (int i = N - 1; i >= 0; i--) if (!m_ok[i]) s = i;
         if (s < 0) begin
            s = m_victim();
            ev_any = 1; ev_vpn = m_vpn[s]; ev_asid = m_asid[s];
         end
      end
      m_ok[s] = 1; m_vpn[s] = v; m_asid[s] = a; m_pfn[s] = p; m_perm[s] = r; m_pv[s] = pv;
      m_touch(s);
   endfunction

   task automatic quiet();
      lk_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_valid = 0;
   endtask

   // drives a lookup (optionally with a refill / flush the same cycle) and checks it
   task automatic op(input string req, input bit do_lk, input logic [VW-1:0] v, input logic [AW-1:0] a,
                     input bit do_fill, input logic [VW-1:0] fv, input logic [AW-1:0] fa,
                     input logic [FW-1:0] fp, input logic [RW-1:0] fr, input bit fpv,
                     input bit fl_all, input bit fl_tag, input logic [AW-1:0] ft);
      int idx;
      logic [2:0] ef; logic [FW-1:0] ep; logic [RW-1:0] er;
      @(negedge clk);
      quiet();
      lk_valid = do_lk; lk_vpn = v; lk_asid = a;
      fill_valid = do_fill; fill_vpn = fv; fill_asid = fa; fill_pfn = fp; fill_perm = fr; fill_pvalid = fpv;
      flush_all = fl_all; flush_asid_valid = fl_tag; flush_asid = ft;
      #1;
      idx = do_lk ? m_find(v, a) : -1;
      ep = '0; er = '0;
      if (!do_lk) ef = 3'b000;
      else if (idx < 0) ef = 3'b010;
      else if (m_pv[idx]) begin ef = 3'b100; ep = m_pfn[idx]; er = m_perm[idx]; end
      else ef = 3'b001;
      chk({lk_hit, lk_miss, lk_fault} == ef && lk_pfn == ep && lk_perm == er, req,
          {36'd0, lk_hit, lk_miss, lk_fault, lk_perm, lk_pfn}, {36'd0, ef, er, ep});
      @(posedge clk);
      if (idx >= 0) m_touch(idx);
      if (fl_all) for (int i = 0; i < N; i++) m_ok[i] = 0;
      else if (fl_tag) begin
         for (int i = 0; i < N; i++) if (m_asid[i] == ft) m_ok[i] = 0;
      end else if (do_fill) m_fill(fv, fa, fp, fr, fpv);
   endtask

   task automatic look(input string req, input logic [VW-1:0] v, input logic [AW-1:0] a);
      op(req, 1, v, a, 0, '0, '0, '0, '0, 0, 0, 0, '0);
   endtask

   task automatic fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                       input logic [FW-1:0] p, input logic [RW-1:0] r, input bit pv);
      op("R12_idle_during_fill", 0, '0, '0, 1, v, a, p, r, pv, 0, 0, '0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_ok[i] = 0;
      for (int i = 0; i < N - 1; i++) m_tree[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: empty after reset
      for (int i = 0; i < 4; i++) look("R1_reset_miss", VW'(i * 7), AW'(i));

      // R5: refill and lookup same key in same cycle sees old contents, then hit
      op("R5_same_cycle_old", 1, 20'h00077, 8'h05, 1, 20'h00077, 8'h05, 20'h12345, 3'd6, 1, 0, 0, '0);
      look("R5_visible_next", 20'h00077, 8'h05);

      // R9: flush all
      op("R9_flush_cycle", 1, 20'h00077, 8'h05, 0, '0, '0, '0, '0, 0, 1, 0, '0);
      look("R9_after_flush", 20'h00077, 8'h05);

      // R2/R4: fill all slots; entry 5 is not present
      for (int i = 0; i < N; i++)
         fill(20'h00100 + VW'(i), AW'(i % 3), 20'h0A000 + FW'(i), RW'(i % 8), i != 5);
      for (int i = 0; i < N; i++) look(i == 5 ? "R4_fault" : "R2_hit", 20'h00100 + VW'(i), AW'(i % 3));
      for (int i = 0; i < N; i++) look("R2_wrong_tag_miss", 20'h00100 + VW'(i), AW'(i % 3 + 1) + 8'd3);
      look("R3_unknown_page_miss", 20'hFFFFF, 8'h00);

      // R6: rewrite existing key in place, nothing displaced
      fill(20'h00103, 8'h00, 20'hBEEF0, 3'd7, 1);
      for (int i = 0; i < N; i++) look("R6_in_place", 20'h00100 + VW'(i), AW'(i % 3));
      fill(20'h00105, 8'h02, 20'h0C005, 3'd1, 1);
      look("R6_fault_cleared", 20'h00105, 8'h02);

      // R10: per-tag flush of tag 1
      op("R10_flush_cycle", 0, '0, '0, 0, '0, '0, '0, '0, 0, 0, 1, 8'h01);
      for (int i = 0; i < N; i++) look("R10_selective", 20'h00100 + VW'(i), AW'(i % 3));

      // R7: holes are taken before any eviction
      for (int i = 0; i < 5; i++) fill(20'h00200 + VW'(i), 8'h09, 20'h0D000 + FW'(i), 3'd2, 1);
      for (int i = 0; i < N; i++) look("R7_survivor", 20'h00100 + VW'(i), AW'(i % 3));
      for (int i = 0; i < 5; i++) look("R7_new", 20'h00200 + VW'(i), 8'h09);

      // R8: pseudo-random touch pattern then evict
      for (int it = 0; it < 80; it++) begin
         for (int k = 0; k < 2; k++) begin
            int s;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = int'(lfsr[3:0]);
            look("R8_touch", m_vpn[s], m_asid[s]);
         end
         fill(20'h04000 + VW'(it), AW'(it % 4), 20'h0E000 + FW'(it), RW'(it % 8), 1);
         if (ev_any) look("R8_victim_gone", ev_vpn, ev_asid);
         look("R8_new_present", 20'h04000 + VW'(it), AW'(it % 4));
         if (it % 10 == 9)
            for (int s = 0; s < N; s++) look("R8_survivors", m_vpn[s], m_asid[s]);
      end

      // R11: refill dropped during flushes
      op("R11_fill_with_tag_flush", 0, '0, '0, 1, 20'h0AAAA, 8'h33, 20'h1, 3'd1, 1, 0, 1, 8'h77);
      look("R11_dropped_tag", 20'h0AAAA, 8'h33);
      op("R11_fill_with_flush", 0, '0, '0, 1, 20'h0BBBB, 8'h34, 20'h2, 3'd1, 1, 1, 1, 8'h77);
      look("R11_dropped_all", 20'h0BBBB, 8'h34);
      for (int i = 0; i < 3; i++) look("R11_all_wins", 20'h04000 + VW'(79 - i), AW'((79 - i) % 4));

      @(negedge clk); quiet(); #1;
      chk(!lk_hit && !lk_miss && !lk_fault && lk_pfn == '0, "R12_idle", {lk_hit, lk_miss, lk_fault}, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule